// File: doc/BRIEF.md
# Variable-Width Queued SPI Master

This block is an SPI master fed from a small transmit queue. Software writes 32-bit entries through a register port. The top byte of each entry gives the number of bits to shift. The lower 24 bits hold the data, left-aligned, and are sent MSB first. The write address decides whether chip select is released after the entry or stays asserted so the next entry continues the same frame. Received bits are collected right-aligned into a receive queue, and software pops them by reading the data address.

SCK comes from a programmable divider. Its idle level and the edges used to drive and capture data are selectable. A status word reports both queue levels, full and empty flags, a busy flag and the bit count of the current entry. One interrupt line combines a transmit-empty condition and an idle condition, each with its own enable. Writing the flush bit empties both queues and aborts any transfer in progress.

The engine is a four-state machine:
- **ST_IDLE**: waits for an entry.
- **ST_SHIFT**: clocks the bits.
- **ST_CSWAIT**: holds chip select for one more SCK period before releasing it.
- **ST_GAP**: keeps SCK idle between entries.

Its transitions are:
- **start** (ST_IDLE→ST_SHIFT): the block is enabled and the queue is not empty.
- **last-bit-release** (ST_SHIFT→ST_CSWAIT)
- **last-bit-hold** (ST_SHIFT→ST_GAP)
- **cs-timeout** (ST_CSWAIT→ST_GAP)
- **gap-done** (ST_GAP→ST_IDLE)
- **flush**: from any state to ST_IDLE.

Length fields of 0 or above 24 are treated as 24.

Register addresses:
- 0: control word A.
- 1: control word B.
- 2: status.
- 3: data. A write queues an entry that releases chip select. A read pops the receive queue.
- 4: hold. A write queues an entry that keeps chip select asserted. A read peeks at the receive queue without popping it.

Top module: `vws_master`

## Requirements
- R1: After reset, cs_n is 1, sck is 0 and irq is 0. The status word reads 0x00000280: TX-empty (bit 9) and RX-empty (bit 7) are set, and busy (bit 6), both levels and the bit count are zero.
- R2: The SCK period is 2×(speed+1) system clocks, so each half period is speed+1 clocks. Speed is control-A bits 31:20 (0 to 4095).
- R3: A transmit entry shifts the number of bits given in its bits 31:24, starting at bit 23 and moving downward (MSB first). It produces exactly one SCK period per bit, and the status bit count (bits 5:0) never exceeds 24.
- R4: A completed entry places its received bits right-aligned in a receive word. The first bit captured lands at position n-1 and all higher bits are zero. Reading address 3 returns the oldest word and pops it.
- R5: An entry written to address 4 leaves cs_n low after it completes, through to the following entry. An entry written to address 3 releases cs_n. cs_n is always low while bits are shifting.
- R6: After a released entry, cs_n rises exactly 2×(speed+1) clocks after its final trailing SCK edge.
- R7: Between two entries of one held frame, SCK stays idle at least two clocks longer than a normal half period.
- R8: The transmit queue holds 4 entries. A write while it is full is dropped. Status bits 31:24 give its level and bit 10 flags full.
- R9: The receive queue holds 4 words. A word completed while it is full is discarded, and a read while it is empty returns 0. Status bits 23:16 give its level and bit 8 flags full.
- R10: While enable (control-A bit 11) is 0, no entry starts: queued entries stay queued, cs_n stays high and busy stays low.
- R11: Control-A bit 7 sets the SCK idle level. Bit 10 set captures MISO on rising SCK edges, otherwise on falling edges. Bit 8 set advances MOSI on rising edges, otherwise on falling edges.
- R12: irq equals (control-B bit 7 AND TX queue empty) OR (control-B bit 6 AND NOT busy). Busy (status bit 6) is high from the start of an entry until its gap ends.
- R13: Writing control A with bit 9 set empties both queues and aborts any entry. By the second clock after the write, cs_n is 1, sck is at the newly written idle level, busy is 0 and the bit count is 0. Bit 9 reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops RX at address 3) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |
| irq | output | 1 | Interrupt request |

## Verification
MISO is looped back to MOSI, and the bench also captures MOSI on the selected sample edge. Entries of 8, 16 and 24 bits carry asymmetric patterns (A5, C35A, 123456), so a bit reversal or a misaligned receive word gives a different value. Divider settings 0, 1 and 2 are compared through measured SCK edge intervals, and held and released entries are compared through cs_n edge counts and the delay after the last trailing edge. Both polarity and edge configurations are run. Queue overflow, RX overflow, disable and a mid-entry flush each leave a level or flag pattern that differs from normal operation.

// File: rtl/vws_pkg.sv
package vws_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_CSWAIT = 2'd2,
        ST_GAP    = 2'd3
    } vws_state_e;

    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_CTRLA = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRLB = 3'd1;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd2;
    localparam logic [ADDR_W-1:0] A_DATA  = 3'd3;
    localparam logic [ADDR_W-1:0] A_HOLD  = 3'd4;

    localparam int CA_SPEED_LSB = 20;
    localparam int CA_ENABLE    = 11;
    localparam int CA_IN_RISE   = 10;
    localparam int CA_FLUSH     = 9;
    localparam int CA_OUT_RISE  = 8;
    localparam int CA_CPOL      = 7;
    localparam int CB_IE_TXE    = 7;
    localparam int CB_IE_IDLE   = 6;

endpackage

// File: rtl/vws_fifo.sv
module vws_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [LW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign full    = (cnt_q == LW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp_q];
    assign level   = cnt_q;

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wp_q] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else if (flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
            if (do_pop)  rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/vws_engine.sv
module vws_engine
    import vws_pkg::*;
#(
    parameter int DATA_W  = 24,
    parameter int LEN_W   = 8,
    parameter int SPEED_W = 12,
    parameter int CNT_W   = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    enable,
    input  logic [SPEED_W-1:0]      speed,
    input  logic                    cpol,
    input  logic                    in_rise,
    input  logic                    out_rise,
    input  logic                    tx_valid,
    input  logic [LEN_W+DATA_W-1:0] tx_word,
    input  logic                    tx_hold,
    output logic                    tx_pop,
    input  logic                    miso,
    output logic                    sck,
    output logic                    mosi,
    output logic                    cs_n,
    output logic                    rx_push,
    output logic [DATA_W-1:0]       rx_word,
    output logic                    busy,
    output logic                    shifting,
    output logic                    gapping,
    output logic [CNT_W-1:0]        bitcnt
);
    localparam int WORD_W = LEN_W + DATA_W;

    vws_state_e        st_q, st_d;
    logic [SPEED_W-1:0] div_q;
    logic              phase_q, sck_q, csn_q, hold_q;
    logic [CNT_W-1:0]  bits_q, nbits_q, eff_len;
    logic [DATA_W-1:0] txsh_q, rxsh_q, rx_next;
    logic [LEN_W-1:0]  len_f;
    logic              div_hit, edge_now, rise_now, cap_now, done, start;

    assign len_f    = tx_word[WORD_W-1 -: LEN_W];
    assign eff_len  = (len_f == '0 || len_f > LEN_W'(DATA_W)) ? CNT_W'(DATA_W)
                                                             : len_f[CNT_W-1:0];
    assign div_hit  = (div_q == speed);
    assign edge_now = (st_q == ST_SHIFT) && div_hit;
    assign rise_now = ~sck_q;
    assign cap_now  = edge_now && (rise_now == in_rise);
    assign done     = edge_now && phase_q && ((bits_q + CNT_W'(1)) == nbits_q);
    assign start    = (st_q == ST_IDLE) && enable && tx_valid;
    assign rx_next  = cap_now ? {rxsh_q[DATA_W-2:0], miso} : rxsh_q;

    assign tx_pop   = start && !clear;
    assign rx_push  = done && !clear;
    assign rx_word  = rx_next;
    assign sck      = sck_q;
    assign mosi     = txsh_q[DATA_W-1];
    assign cs_n     = csn_q;
    assign busy     = (st_q != ST_IDLE);
    assign shifting = (st_q == ST_SHIFT);
    assign gapping  = (st_q == ST_GAP);
    assign bitcnt   = bits_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (start) st_d = ST_SHIFT;
            ST_SHIFT:  if (done) st_d = hold_q ? ST_GAP : ST_CSWAIT;
            ST_CSWAIT: if (div_hit && phase_q) st_d = ST_GAP;
            ST_GAP:    if (div_q == SPEED_W'(1)) st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     st_q <= ST_IDLE;
        else if (clear) st_q <= ST_IDLE;
        else            st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q   <= '0;
            phase_q <= 1'b0;
            sck_q   <= 1'b0;
            csn_q   <= 1'b1;
            hold_q  <= 1'b0;
            bits_q  <= '0;
            nbits_q <= '0;
            txsh_q  <= '0;
            rxsh_q  <= '0;
        end else if (clear) begin
            div_q   <= '0;
            phase_q <= 1'b0;
            sck_q   <= cpol;
            csn_q   <= 1'b1;
            bits_q  <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    sck_q   <= cpol;
                    div_q   <= '0;
                    phase_q <= 1'b0;
                    if (start) begin
                        txsh_q  <= tx_word[DATA_W-1:0];
                        rxsh_q  <= '0;
                        nbits_q <= eff_len;
                        hold_q  <= tx_hold;
                        bits_q  <= '0;
                        csn_q   <= 1'b0;
                    end
                end
                ST_SHIFT: begin
                    if (div_hit) begin
                        div_q   <= '0;
                        sck_q   <= ~sck_q;
                        phase_q <= ~phase_q;
                        rxsh_q  <= rx_next;
                        if (rise_now == out_rise) txsh_q <= txsh_q << 1;
                        if (phase_q) bits_q <= bits_q + 1'b1;
                    end else begin
                        div_q <= div_q + 1'b1;
                    end
                end
                ST_CSWAIT: begin
                    sck_q <= cpol;
                    if (div_hit) begin
                        div_q   <= '0;
                        phase_q <= ~phase_q;
                        if (phase_q) csn_q <= 1'b1;
                    end else begin
                        div_q <= div_q + 1'b1;
                    end
                end
                ST_GAP: begin
                    sck_q <= cpol;
                    div_q <= div_q + 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/vws_master.sv
module vws_master
    import vws_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int DATA_W  = 24,
    parameter int LEN_W   = 8,
    parameter int SPEED_W = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        sck,
    output logic        mosi,
    input  logic        miso,
    output logic        cs_n,
    output logic        irq
);
    localparam int WORD_W = LEN_W + DATA_W;
    localparam int LVL_W  = $clog2(DEPTH + 1);
    localparam int CNT_W  = $clog2(DATA_W + 1);

    logic [31:0]        ca_q, cb_q;
    logic               flush, tx_push, tx_pop, rx_push, rx_pop;
    logic               tx_full, tx_empty, rx_full, rx_empty;
    logic [LVL_W-1:0]   tx_lvl, rx_lvl;
    logic [WORD_W:0]    tx_dout;
    logic [DATA_W-1:0]  rx_din, rx_dout;
    logic               busy, shifting, gapping;
    logic [CNT_W-1:0]   bitcnt;
    logic               enable, cpol;

    assign enable  = ca_q[CA_ENABLE];
    assign cpol    = ca_q[CA_CPOL];
    assign flush   = bus_wr && (bus_addr == A_CTRLA) && bus_wdata[CA_FLUSH];
    assign tx_push = bus_wr && ((bus_addr == A_DATA) || (bus_addr == A_HOLD));
    assign rx_pop  = bus_rd && (bus_addr == A_DATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ca_q <= '0;
            cb_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_CTRLA) ca_q <= bus_wdata & ~(32'd1 << CA_FLUSH);
            if (bus_addr == A_CTRLB) cb_q <= bus_wdata;
        end
    end

    vws_fifo #(.W(WORD_W + 1), .DEPTH(DEPTH)) tx_fifo_i (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(tx_push), .din({bus_addr == A_HOLD, bus_wdata[WORD_W-1:0]}),
        .pop(tx_pop), .dout(tx_dout), .level(tx_lvl),
        .full(tx_full), .empty(tx_empty)
    );

    vws_fifo #(.W(DATA_W), .DEPTH(DEPTH)) rx_fifo_i (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(rx_push), .din(rx_din),
        .pop(rx_pop), .dout(rx_dout), .level(rx_lvl),
        .full(rx_full), .empty(rx_empty)
    );

    vws_engine #(.DATA_W(DATA_W), .LEN_W(LEN_W), .SPEED_W(SPEED_W), .CNT_W(CNT_W)) eng_i (
        .clk(clk), .rst_n(rst_n), .clear(flush), .enable(enable),
        .speed(ca_q[CA_SPEED_LSB +: SPEED_W]), .cpol(cpol),
        .in_rise(ca_q[CA_IN_RISE]), .out_rise(ca_q[CA_OUT_RISE]),
        .tx_valid(!tx_empty), .tx_word(tx_dout[WORD_W-1:0]), .tx_hold(tx_dout[WORD_W]),
        .tx_pop(tx_pop), .miso(miso), .sck(sck), .mosi(mosi), .cs_n(cs_n),
        .rx_push(rx_push), .rx_word(rx_din), .busy(busy),
        .shifting(shifting), .gapping(gapping), .bitcnt(bitcnt)
    );

    assign irq = (cb_q[CB_IE_TXE] && tx_empty) || (cb_q[CB_IE_IDLE] && !busy);

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRLA: bus_rdata = ca_q;
            A_CTRLB: bus_rdata = cb_q;
            A_STAT:  bus_rdata = {8'(tx_lvl), 8'(rx_lvl), 5'd0, tx_full, tx_empty,
                                  rx_full, rx_empty, busy, 6'(bitcnt)};
            A_DATA, A_HOLD: bus_rdata = rx_empty ? 32'd0 : 32'(rx_dout);
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/vws_master_chk.sv
module vws_master_chk #(
    parameter int DEPTH  = 4,
    parameter int LW     = 3,
    parameter int DATA_W = 24,
    parameter int CNT_W  = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clear,
    input logic          enable,
    input logic          cpol,
    input logic          sck,
    input logic          cs_n,
    input logic          in_shift,
    input logic          in_gap,
    input logic          busy,
    input logic          tx_push,
    input logic          tx_pop,
    input logic          rx_push,
    input logic          rx_pop,
    input logic          tx_full,
    input logic          rx_full,
    input logic [LW-1:0] tx_lvl,
    input logic [LW-1:0] rx_lvl,
    input logic [CNT_W-1:0] bitcnt
);
    // R5: chip select is asserted whenever the shift state is active
    p_cs_low_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_shift |-> !cs_n);

    // R8: a write to a full transmit queue leaves it full
    p_tx_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && tx_push && !tx_pop && !clear) |=> (tx_lvl == LW'(DEPTH)));

    // R9: a completion while the receive queue is full leaves it full
    p_rx_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && rx_push && !rx_pop && !clear) |=> (rx_lvl == LW'(DEPTH)));

    // R13: flush empties both queues and releases chip select
    p_flush_r13: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (tx_lvl == '0 && rx_lvl == '0 && cs_n && !in_shift));

    // R11: sck rests at its idle level in the gap state
    p_gap_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_gap |-> (sck == cpol));

    // R10: a disabled idle engine stays idle
    p_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !busy) |=> !busy);

    // R3: bit count never exceeds the data width
    p_bitcnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt <= CNT_W'(DATA_W));
endmodule

bind vws_master vws_master_chk #(.DEPTH(DEPTH), .LW(LVL_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .clear(flush), .enable(enable), .cpol(cpol),
    .sck(sck), .cs_n(cs_n), .in_shift(shifting), .in_gap(gapping), .busy(busy),
    .tx_push(tx_push), .tx_pop(tx_pop), .rx_push(rx_push), .rx_pop(rx_pop),
    .tx_full(tx_full), .rx_full(rx_full), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl),
    .bitcnt(bitcnt)
);

// File: tb/vws_master_tb_top.sv
module vws_master_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sck, mosi, miso, cs_n, irq;

    int nchk = 0, nbad = 0, cyc = 0;
    int rises, minv, maxv, last_edge, last_trail, cs_rises, cs_rise_cyc;
    bit seen;
    logic [31:0] mon_sh;
    logic sck_l = 1'b0, cs_l = 1'b1;
    logic mon_cpol = 1'b0, mon_in_rise = 1'b1;

    assign miso = mosi;

    vws_master dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD_LIMIT) begin
            nchk++; nbad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (sck !== sck_l) begin
            if (seen) begin
                if (cyc - last_edge < minv) minv = cyc - last_edge;
                if (cyc - last_edge > maxv) maxv = cyc - last_edge;
            end
            if (sck) rises++;
            if (sck == mon_cpol) last_trail = cyc;
            if (sck == mon_in_rise) mon_sh = {mon_sh[30:0], mosi};
            last_edge = cyc;
            seen = 1'b1;
            sck_l = sck;
        end
        if (cs_n && !cs_l) begin cs_rises++; cs_rise_cyc = cyc; end
        cs_l = cs_n;
    end

    task automatic clear_mon();
        rises = 0; minv = 1000000; maxv = 0; seen = 1'b0;
        mon_sh = '0; cs_rises = 0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 20000; i++) begin
            reg_read(3'd2, s);
            if (!s[6] && s[9]) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] s;
        reg_read(3'd2, s);
        chk("R1 status", s, 32'h0000_0280);
        chk("R1 cs_n", 32'(cs_n), 32'd1);
        chk("R1 sck", 32'(sck), 32'd0);
        chk("R1 irq", 32'(irq), 32'd0);
    endtask

    task automatic t_widths();
        logic [31:0] d;
        mon_cpol = 1'b0; mon_in_rise = 1'b1;
        reg_write(3'd0, 32'h0020_0C00);
        clear_mon();
        reg_write(3'd3, 32'h08A5_0000);
        wait_idle();
        chk("R3 rises 8", 32'(rises), 32'd8);
        chk("R2 half period speed2", 32'(minv), 32'd3);
        chk("R3 mosi order 8", mon_sh & 32'hFF, 32'hA5);
        reg_read(3'd3, d);
        chk("R4 rx 8", d, 32'h0000_00A5);
        clear_mon();
        reg_write(3'd3, 32'h10C3_5A00);
        wait_idle();
        chk("R3 rises 16", 32'(rises), 32'd16);
        chk("R3 mosi order 16", mon_sh & 32'hFFFF, 32'hC35A);
        reg_read(3'd3, d);
        chk("R4 rx 16", d, 32'h0000_C35A);
        clear_mon();
        reg_write(3'd3, 32'h1812_3456);
        wait_idle();
        chk("R3 rises 24", 32'(rises), 32'd24);
        reg_read(3'd2, d);
        chk("R3 bitcount", d & 32'h3F, 32'd24);
        reg_read(3'd3, d);
        chk("R4 rx 24", d, 32'h0012_3456);
        reg_write(3'd0, 32'h0000_0C00);
        clear_mon();
        reg_write(3'd3, 32'h0866_0000);
        wait_idle();
        chk("R2 half period speed0", 32'(minv), 32'd1);
        reg_read(3'd3, d);
        chk("R4 rx speed0", d, 32'h0000_0066);
    endtask

    task automatic t_hold();
        logic [31:0] d;
        reg_write(3'd0, 32'h0010_0C00);
        clear_mon();
        reg_write(3'd4, 32'h08F0_0000);
        reg_write(3'd3, 32'h080F_0000);
        wait_idle();
        chk("R5 single cs release", 32'(cs_rises), 32'd1);
        chk("R5 rises", 32'(rises), 32'd16);
        chk("R6 cs delay", 32'(cs_rise_cyc - last_trail), 32'd4);
        chk("R7 gap", 32'(maxv >= 4), 32'd1);
        chk("R2 half period speed1", 32'(minv), 32'd2);
        reg_read(3'd3, d);
        chk("R5 rx first", d, 32'h0000_00F0);
        reg_read(3'd3, d);
        chk("R5 rx second", d, 32'h0000_000F);
        reg_write(3'd4, 32'h08AA_0000);
        wait_idle();
        repeat (5) @(negedge clk);
        chk("R5 held cs_n", 32'(cs_n), 32'd0);
        reg_write(3'd3, 32'h0855_0000);
        wait_idle();
        chk("R5 released cs_n", 32'(cs_n), 32'd1);
        reg_read(3'd3, d);
        chk("R5 rx held", d, 32'h0000_00AA);
        reg_read(3'd3, d);
        chk("R5 rx last", d, 32'h0000_0055);
    endtask

    task automatic t_full();
        logic [31:0] s;
        reg_write(3'd0, 32'h0000_0400);
        for (int k = 1; k <= 5; k++) reg_write(3'd3, 32'h0800_0000 | (32'(k * 8'h11) << 16));
        reg_read(3'd2, s);
        chk("R8 tx level", s >> 24, 32'd4);
        chk("R8 tx full", 32'(s[10]), 32'd1);
        repeat (20) @(negedge clk);
        reg_read(3'd2, s);
        chk("R10 queued", s >> 24, 32'd4);
        chk("R10 busy", 32'(s[6]), 32'd0);
        chk("R10 cs_n", 32'(cs_n), 32'd1);
        reg_write(3'd1, 32'h0000_0080);
        chk("R12 irq txe off", 32'(irq), 32'd0);
        reg_write(3'd1, 32'h0000_0040);
        chk("R12 irq idle", 32'(irq), 32'd1);
        reg_write(3'd1, 32'h0000_0080);
        clear_mon();
        reg_write(3'd0, 32'h0000_0C00);
        wait_idle();
        chk("R12 irq txe", 32'(irq), 32'd1);
        chk("R8 dropped entry", 32'(rises), 32'd32);
        reg_write(3'd1, 32'h0);
        reg_read(3'd2, s);
        chk("R9 rx level", (s >> 16) & 32'hFF, 32'd4);
        chk("R9 rx full", 32'(s[8]), 32'd1);
        for (int k = 1; k <= 4; k++) begin
            reg_read(3'd3, s);
            chk("R8 order", s, 32'(k * 8'h11));
        end
        reg_read(3'd3, s);
        chk("R9 empty read", s, 32'd0);
    endtask

    task automatic t_rx_over();
        logic [31:0] s;
        for (int k = 1; k <= 4; k++) reg_write(3'd3, 32'h0860_0000 | (32'(k) << 16));
        wait_idle();
        reg_write(3'd3, 32'h0899_0000);
        wait_idle();
        reg_read(3'd2, s);
        chk("R9 rx level kept", (s >> 16) & 32'hFF, 32'd4);
        for (int k = 1; k <= 4; k++) begin
            reg_read(3'd3, s);
            chk("R9 rx kept", s, 32'h60 + 32'(k));
        end
        reg_read(3'd3, s);
        chk("R9 overflow discarded", s, 32'd0);
    endtask

    task automatic t_cpol();
        logic [31:0] d;
        reg_write(3'd0, 32'h0010_0980);
        mon_cpol = 1'b1; mon_in_rise = 1'b0;
        repeat (2) @(negedge clk);
        sck_l = sck;
        chk("R11 idle high", 32'(sck), 32'd1);
        clear_mon();
        reg_write(3'd3, 32'h10BE_EF00);
        wait_idle();
        chk("R11 rises", 32'(rises), 32'd16);
        chk("R11 mosi order", mon_sh & 32'hFFFF, 32'hBEEF);
        reg_read(3'd3, d);
        chk("R11 rx", d, 32'h0000_BEEF);
        chk("R11 idle after", 32'(sck), 32'd1);
    endtask

    task automatic t_flush();
        logic [31:0] s;
        reg_write(3'd0, 32'h0140_0980);
        reg_write(3'd3, 32'h18AB_CDEF);
        reg_write(3'd3, 32'h0811_0000);
        repeat (30) @(negedge clk);
        reg_read(3'd2, s);
        chk("R12 busy", 32'(s[6]), 32'd1);
        reg_write(3'd0, 32'h0140_0E00);
        mon_cpol = 1'b0; mon_in_rise = 1'b1;
        @(negedge clk);
        chk("R13 cs_n", 32'(cs_n), 32'd1);
        chk("R13 sck", 32'(sck), 32'd0);
        reg_read(3'd2, s);
        chk("R13 status", s, 32'h0000_0280);
        reg_read(3'd0, s);
        chk("R13 flush bit reads 0", s, 32'h0140_0C00);
        sck_l = sck;
        reg_write(3'd0, 32'h0000_0C00);
        reg_write(3'd3, 32'h083C_0000);
        wait_idle();
        reg_read(3'd3, s);
        chk("R13 after flush", s, 32'h0000_003C);
    endtask

    initial begin
        clear_mon();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_widths();
        t_hold();
        t_full();
        t_rx_over();
        t_cpol();
        t_flush();
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule